// File: doc/BRIEF.md
# Vector Lane Insert-and-Zero Unit

This execution unit carries out a four-lane insert on 128-bit vectors of 32-bit elements. From an 8-bit control byte it picks one 32-bit element from a second source. It writes that element into one chosen lane of the first source. It then forces to zero every lane whose mask bit is set. The second source is either a full vector register or a single 32-bit memory word, which is presented on the low lane of the second-source port. Elements are treated as opaque bits. No arithmetic is performed, so every pattern, NaNs included, passes through unchanged.

Beyond the 128-bit result, the destination register extends to a parameterised maximum vector length. The two encoding forms treat these upper bits differently. The legacy two-operand form keeps the prior upper bits of the destination. The extended three-operand form clears them. An extended encoding that asks for a 256-bit vector length is invalid: the unit raises a fault and suppresses the register write. Inputs are taken on a valid strobe, and the result, its write enable and the fault flag appear one clock later.

Top module: `vec_lane_insert`

## Requirements
- R1: With a register second source (`src2_is_mem_i`=0), control bits [7:6] select which 32-bit lane of `src2_i` is inserted (lane n occupies bits 32n+31:32n).
- R2: With a memory second source (`src2_is_mem_i`=1), control bits [7:6] are ignored and `src2_i[31:0]` is the inserted element.
- R3: Control bits [5:4] name the one destination lane that receives the element; the other three lanes of the result equal the matching lanes of `src1_i`.
- R4: Control bits [3:0] are a zero mask applied after the insert: when bit n is set, result lane n is all zeros, even if it is the lane that received the element.
- R5: In the legacy form (`ext_form_i`=0), result bits MAXVL-1:128 equal `prev_hi_i`.
- R6: In the extended form (`ext_form_i`=1), result bits MAXVL-1:128 are zero.
- R7: A strobe with `ext_form_i`=1 and `len256_i`=1 sets `fault_o` one cycle later with `wen_o` low. In the legacy form, `len256_i` has no effect.
- R8: Every accepted strobe yields exactly one cycle with `valid_o` high one clock later, and `wen_o` equals `valid_o` and not `fault_o`.
- R9: A synchronous active-high reset drives `valid_o`, `wen_o` and `fault_o` low, even when strobes arrive during reset.
- R10: Element bits pass through bit-exact, including NaN and sign patterns; no exception or status is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation strobe |
| src1_i | input | 128 | First source vector |
| src2_i | input | 128 | Second source vector, or memory word in bits 31:0 |
| src2_is_mem_i | input | 1 | Second source is a 32-bit memory word |
| ctrl_i | input | 8 | Control byte: source lane, destination lane, zero mask |
| ext_form_i | input | 1 | 1 = extended three-operand form, 0 = legacy form |
| len256_i | input | 1 | Encoding requests 256-bit vector length |
| prev_hi_i | input | MAXVL-128 | Prior destination bits MAXVL-1:128 |
| valid_o | output | 1 | Result cycle |
| wen_o | output | 1 | Register write enable |
| fault_o | output | 1 | Undefined-encoding fault |
| data_o | output | MAXVL | Full-width destination value |

## Verification
The assertions check on every cycle the handshake rules: the one-cycle strobe-to-valid latency, that a fault always blocks the write, and that a fault has a cause. They also check, per written result, the masked-lane zeros, the untouched lanes, the inserted lane for register and memory sources, and the upper-bit policy of each form. Only the bench scenarios can show that the right source lane is chosen across every select value, that the ignored select bits really stay ignored, that NaN patterns survive, and that strobes arriving during reset produce no result.

// File: rtl/lane_ins_pkg.sv
package lane_ins_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int IDX_W  = $clog2(LANES);
    localparam int CTRL_W = 2 * IDX_W + LANES;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] vec_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic {
        FORM_LEGACY = 1'b0,
        FORM_EXT    = 1'b1
    } enc_form_e;

    typedef struct packed {
        idx_t             src_lane;
        idx_t             dst_lane;
        logic [LANES-1:0] zmask;
    } ins_ctrl_t;

    // A memory operand is one word, so its lane select is forced to zero.
    function automatic ins_ctrl_t decode_ctrl(logic [CTRL_W-1:0] raw, logic from_mem);
        ins_ctrl_t c;
        c          = ins_ctrl_t'(raw);
        if (from_mem) c.src_lane = '0;
        return c;
    endfunction

endpackage

// File: rtl/lane_pick.sv
module lane_pick
    import lane_ins_pkg::*;
(
    input  vec_t  src,
    input  idx_t  sel,
    output lane_t elem
);
    always_comb begin
        elem = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == idx_t'(i)) elem = src[i];
        end
    end
endmodule

// File: rtl/lane_merge_zero.sv
module lane_merge_zero
    import lane_ins_pkg::*;
(
    input  vec_t             base,
    input  lane_t            elem,
    input  idx_t             dst,
    input  logic [LANES-1:0] zmask,
    output vec_t             res
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t merged;
        assign merged = (dst == idx_t'(g)) ? elem : base[g];
        assign res[g] = zmask[g] ? '0 : merged;
    end
endmodule

// File: rtl/upper_fill.sv
module upper_fill
    import lane_ins_pkg::*;
#(
    parameter int HI_W = 384
) (
    input  enc_form_e       form,
    input  logic [HI_W-1:0] prev_hi,
    output logic [HI_W-1:0] hi
);
    assign hi = (form == FORM_EXT) ? '0 : prev_hi;
endmodule

// File: rtl/vec_lane_insert.sv
module vec_lane_insert
    import lane_ins_pkg::*;
#(
    parameter int MAXVL = 512
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid_i,
    input  logic [VEC_W-1:0]       src1_i,
    input  logic [VEC_W-1:0]       src2_i,
    input  logic                   src2_is_mem_i,
    input  logic [CTRL_W-1:0]      ctrl_i,
    input  logic                   ext_form_i,
    input  logic                   len256_i,
    input  logic [MAXVL-VEC_W-1:0] prev_hi_i,
    output logic                   valid_o,
    output logic                   wen_o,
    output logic                   fault_o,
    output logic [MAXVL-1:0]       data_o
);
    localparam int HI_W = MAXVL - VEC_W;

    ins_ctrl_t        ctrl;
    enc_form_e        form;
    lane_t            elem;
    vec_t             low;
    logic [HI_W-1:0]  hi;
    logic             bad_len;

    assign ctrl    = decode_ctrl(ctrl_i, src2_is_mem_i);
    assign form    = enc_form_e'(ext_form_i);
    assign bad_len = (form == FORM_EXT) && len256_i;

    lane_pick u_pick (
        .src  (vec_t'(src2_i)),
        .sel  (ctrl.src_lane),
        .elem (elem)
    );

    lane_merge_zero u_merge (
        .base  (vec_t'(src1_i)),
        .elem  (elem),
        .dst   (ctrl.dst_lane),
        .zmask (ctrl.zmask),
        .res   (low)
    );

    upper_fill #(.HI_W(HI_W)) u_hi (
        .form    (form),
        .prev_hi (prev_hi_i),
        .hi      (hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            valid_o <= in_valid_i;
            fault_o <= in_valid_i && bad_len;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid_i && !bad_len) data_o <= {hi, low};
    end

    assign wen_o = valid_o && !fault_o;

    // ---------------- assertions ----------------
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> valid_o);
    p_no_stray_result_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !valid_o);
    p_fault_blocks_write_r7: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !wen_o);
    p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && ext_form_i && len256_i |=> fault_o);
    p_legacy_no_fault_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && !ext_form_i |=> !fault_o);
    p_ext_upper_clear_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && ext_form_i |=> !wen_o || data_o[MAXVL-1:VEC_W] == '0);
    p_legacy_upper_keep_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && !ext_form_i |=> data_o[MAXVL-1:VEC_W] == $past(prev_hi_i));
    p_mem_word_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && !bad_len && src2_is_mem_i && !ctrl_i[ctrl_i[5:4]] |=>
        data_o[32*$past(ctrl_i[5:4]) +: 32] == $past(src2_i[31:0]));
    p_reg_lane_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid_i && !bad_len && !src2_is_mem_i && !ctrl_i[ctrl_i[5:4]] |=>
        data_o[32*$past(ctrl_i[5:4]) +: 32] == $past(src2_i[32*ctrl_i[7:6] +: 32]));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        p_zero_lane_r4: assert property (@(posedge clk) disable iff (rst)
            in_valid_i && !bad_len && ctrl_i[g] |=> data_o[g*LANE_W +: LANE_W] == '0);
        p_keep_lane_r3: assert property (@(posedge clk) disable iff (rst)
            in_valid_i && !bad_len && !ctrl_i[g] && ctrl_i[5:4] != 2'(g) |=>
            data_o[g*LANE_W +: LANE_W] == $past(src1_i[g*LANE_W +: LANE_W]));
    end

endmodule

// File: tb/vec_lane_insert_tb.sv
module vec_lane_insert_tb;
    localparam int MAXVL = 512;
    localparam int HI_W  = MAXVL - 128;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [127:0]     src1, src2;
    logic             is_mem;
    logic [7:0]       ctrl;
    logic             ext, l256;
    logic [HI_W-1:0]  prev_hi;
    logic             valid, wen, fault;
    logic [MAXVL-1:0] data;

    always #2 clk = ~clk;

    vec_lane_insert #(.MAXVL(MAXVL)) u_dut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid),
        .src1_i(src1), .src2_i(src2), .src2_is_mem_i(is_mem),
        .ctrl_i(ctrl), .ext_form_i(ext), .len256_i(l256),
        .prev_hi_i(prev_hi),
        .valid_o(valid), .wen_o(wen), .fault_o(fault), .data_o(data)
    );

    typedef struct {
        logic             flt;
        logic [MAXVL-1:0] val;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   n_sent = 0;
    int   n_seen = 0;
    bit   done = 0;

    function automatic logic [MAXVL-1:0] ref_model(
        logic [127:0] a, logic [127:0] b, logic mem, logic [7:0] c,
        logic e, logic [HI_W-1:0] ph);
        logic [31:0]      word;
        logic [MAXVL-1:0] r;
        int               s, d;
        s    = mem ? 0 : int'(c[7:6]);
        d    = int'(c[5:4]);
        word = b[32*s +: 32];
        r    = '0;
        for (int k = 0; k < 4; k++) begin
            if (c[k])        r[32*k +: 32] = 32'h0;
            else if (k == d) r[32*k +: 32] = word;
            else             r[32*k +: 32] = a[32*k +: 32];
        end
        r[MAXVL-1:128] = e ? '0 : ph;
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [MAXVL-1:0] act, logic [MAXVL-1:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(logic [127:0] a, logic [127:0] b, logic mem, logic [7:0] c,
                        logic e, logic len, logic [HI_W-1:0] ph, string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; src1 = a; src2 = b; is_mem = mem; ctrl = c;
        ext = e; l256 = len; prev_hi = ph;
        it.flt = e && len;
        it.val = ref_model(a, b, mem, c, e, ph);
        it.tag = tag;
        exp_q.push_back(it);
        n_sent++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per result cycle.
    always @(negedge clk) begin
        if (!rst && valid) begin
            n_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R8 unexpected result", {511'b0, valid}, '0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                if (it.flt) begin
                    check(fault && !wen, {it.tag, " R7 fault/wen"},
                          {510'b0, fault, wen}, {510'b0, 2'b10});
                end else begin
                    check(!fault && wen, {it.tag, " R8 wen"},
                          {510'b0, fault, wen}, {510'b0, 2'b01});
                    check(data === it.val, it.tag, data, it.val);
                end
            end
        end
    end

    localparam logic [127:0] A = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
    localparam logic [127:0] B = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;
    localparam logic [HI_W-1:0] PH = {12{32'hC0DE_5A5A}};

    initial begin
        rst = 1'b1; in_valid = 1'b0; src1 = '0; src2 = '0; is_mem = 1'b0;
        ctrl = '0; ext = 1'b0; l256 = 1'b0; prev_hi = '0;
        // R9: strobes during reset must produce nothing
        repeat (2) @(negedge clk);
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        check(!valid && !wen && !fault, "R9 reset flags",
              {509'b0, valid, wen, fault}, '0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(!valid && !wen && !fault, "R9 idle after reset",
              {509'b0, valid, wen, fault}, '0);

        // R1: every source lane, register source
        for (int s = 0; s < 4; s++)
            send(A, B, 1'b0, {2'(s), 2'd3, 4'b0000}, 1'b1, 1'b0, PH, "R1 source lane");
        send(A, B, 1'b0, 8'b10_01_0000, 1'b0, 1'b0, PH, "R1 lane2->lane1");
        // R2: memory source ignores select bits
        send(A, B, 1'b1, 8'b11_10_0000, 1'b1, 1'b0, PH, "R2 memory word");
        send(A, B, 1'b1, 8'b01_00_0000, 1'b0, 1'b0, PH, "R2 memory word lane0");
        // R3: every destination lane
        for (int d = 0; d < 4; d++)
            send(A, B, 1'b0, {2'd1, 2'(d), 4'b0000}, 1'b1, 1'b0, PH, "R3 dest lane");
        idle(2);
        // R4: masks, including the inserted lane
        send(A, B, 1'b0, 8'b11_01_0010, 1'b1, 1'b0, PH, "R4 mask hits inserted lane");
        send(A, B, 1'b0, 8'b00_10_0101, 1'b1, 1'b0, PH, "R4 mask 0101");
        send(A, B, 1'b0, 8'b10_11_1111, 1'b0, 1'b0, PH, "R4 mask all");
        // R5 / R6: upper bits policy
        send(A, B, 1'b0, 8'b00_00_0000, 1'b0, 1'b0, PH, "R5 legacy keeps upper");
        send(A, B, 1'b0, 8'b00_00_0000, 1'b0, 1'b0, ~PH, "R5 legacy keeps upper inv");
        send(A, B, 1'b0, 8'b00_00_0000, 1'b1, 1'b0, PH, "R6 extended clears upper");
        // R7: fault, then legacy ignoring len256
        send(A, B, 1'b0, 8'b01_10_0000, 1'b1, 1'b1, PH, "R7 bad length");
        send(A, B, 1'b0, 8'b01_10_0000, 1'b0, 1'b1, PH, "R7 legacy ignores length");
        send(A, B, 1'b0, 8'b11_00_1000, 1'b1, 1'b0, PH, "R7 recovery after fault");
        idle(1);
        // R10: NaN and sign patterns pass bit-exact
        send(A, 128'h7FC00001_FF800000_80000000_7F800001, 1'b0, 8'b00_10_0000,
             1'b1, 1'b0, PH, "R10 signalling NaN");
        send(128'hFFFFFFFF_7FFFFFFF_00000001_80000000,
             128'h7FC00001_FF800000_80000000_7F800001, 1'b0, 8'b11_01_0000,
             1'b0, 1'b0, PH, "R10 quiet NaN");
        idle(4);
        check(exp_q.size() == 0 && n_seen == n_sent, "R8 one result per strobe",
              MAXVL'(n_seen), MAXVL'(n_sent));
        done = 1;
    end

    initial begin
        for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule